// File: doc/BRIEF.md
# PCIe Slot Power-Up Reset Sequencer

This block brings a PCIe endpoint slot out of power-off in hardware. On a start request it switches on slot power and waits for the supply to report good. It then enables the reference clock and holds the fundamental reset (PERST#, active low) asserted for a fixed minimum time. After releasing reset it watches a link-active status bit for a bounded window. When the root port advertises a speed above 5 GT/s, it adds a settling delay after link-up. It then raises a ready flag, which tells the rest of the chip that configuration requests may be issued.

Every delay is counted in clock cycles, computed from a clock-frequency parameter and a time parameter for each delay. A start request while a sequence is active aborts it, so start acts as a toggle between idle and a fresh bring-up. A link that never comes up leaves the block in a latched fault until the next start. All pins are plain control and status levels. No data stream passes through the block, so no pin needs a valid/ready handshake.

Top module: `slot_bringup_seq`

## Requirements
- R1: After reset, and whenever the block is idle, pwr_en, refclk_en, perst_n, ready and timeout_err are all 0.
- R2: A start pulse in idle sets pwr_en in the next cycle. While pwr_good stays low, refclk_en and perst_n stay 0 for as long as it stays low.
- R3: refclk_en rises in the cycle after the first clock edge that samples pwr_good high. The reset-hold interval starts in that same cycle.
- R4: perst_n stays 0 for exactly HOLD cycles with refclk_en at 1, then rises. HOLD is the larger of ceil(CLK_HZ*PERST_MS/1000) and ceil(CLK_HZ*LEAD_US/1e6), so both the 100 ms power-stable hold and the 100 us clock lead are met.
- R5: After perst_n rises, a link_up sampled high in any of the first POLL = ceil(CLK_HZ*POLL_MS/1000) cycles is accepted. This includes the last of those cycles, where link-up wins over expiry.
- R6: max_speed is sampled in the link-up cycle, with codes 0 = 2.5 GT/s, 1 = 5 GT/s and 2 or 3 = faster. For codes 0 and 1, ready rises in the cycle after link_up is sampled. For codes 2 and 3, ready rises after a further SETTLE = ceil(CLK_HZ*SETTLE_MS/1000) cycles, with perst_n held at 1 throughout. Once high, ready stays high until start or reset.
- R7: If link_up is not seen within POLL cycles, timeout_err becomes 1 and perst_n returns to 0, while pwr_en and refclk_en stay at 1. ready stays 0. The fault is held even if link_up rises later.
- R8: A start pulse in any non-idle state returns the block to idle in the next cycle, including the ready and fault states. This clears timeout_err. A later start pulse begins a complete new sequence.
- R9: Asserting rst_n low in the middle of a sequence forces the idle outputs of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request from idle, abort from any other state |
| pwr_good | input | 1 | Slot supply within limits |
| link_up | input | 1 | Link-active status from the link layer |
| max_speed | input | 2 | Root-side advertised maximum speed code |
| pwr_en | output | 1 | Slot power enable |
| refclk_en | output | 1 | Reference clock enable |
| perst_n | output | 1 | Slot fundamental reset, active low |
| ready | output | 1 | Configuration requests permitted |
| timeout_err | output | 1 | Link-up window expired (latched) |

## Verification
The link-up input and the expiry of the polling window can fall in the same cycle. The bench provokes this by raising link_up exactly POLL-1 cycles after the first cycle with perst_n high, which lands it in the last cycle of the window. In that case ready must follow with no timeout_err. One cycle later, the same stimulus must instead find timeout_err already set and ready held low. A sweep over all four speed codes confirms the ready delay of 1 or SETTLE+1 cycles, and the bench also checks every reset-hold length against the HOLD value it computes itself.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_HOLD,
    ST_POLL,
    ST_SETTLE,
    ST_READY,
    ST_FAULT
  } sbs_state_e;

  // cycles covering amt units of 1/unit seconds, rounded up, never zero
  function automatic int unsigned cycles_for(int unsigned hz, int unsigned amt,
                                             int unsigned unit);
    longint unsigned p;
    p = (64'(hz) * 64'(amt) + 64'(unit) - 64'd1) / 64'(unit);
    if (p == 64'd0) p = 64'd1;
    return 32'(p);
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sbs_timer.sv
module sbs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R4: an expired count never wraps back to a large value
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

endmodule

// File: rtl/sbs_speed.sv
module sbs_speed #(
  parameter logic [1:0] FAST_MIN = 2'd2
) (
  input  logic [1:0] max_speed,
  output logic       fast
);
  // codes at or above FAST_MIN advertise more than 5 GT/s
  assign fast = (max_speed >= FAST_MIN);
endmodule

// File: rtl/sbs_fsm.sv
module sbs_fsm
  import sbs_pkg::*;
#(
  parameter int          CW         = 8,
  parameter int unsigned HOLD_CYC   = 4,
  parameter int unsigned POLL_CYC   = 4,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pwr_good,
  input  logic          link_up,
  input  logic          fast,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output sbs_state_e    st_next
);
  localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] POLL_LD   = CW'(POLL_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);

  sbs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start) begin
      st_d = (st_q == ST_IDLE) ? ST_PWR : ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:   st_d = ST_IDLE;
        ST_PWR:    if (pwr_good) st_d = ST_HOLD;
        ST_HOLD:   if (tmr_zero) st_d = ST_POLL;
        ST_POLL: begin
          if (link_up)       st_d = fast ? ST_SETTLE : ST_READY;
          else if (tmr_zero) st_d = ST_FAULT;
        end
        ST_SETTLE: if (tmr_zero) st_d = ST_READY;
        ST_READY:  st_d = ST_READY;
        ST_FAULT:  st_d = ST_FAULT;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_load = (st_d != st_q);
    case (st_d)
      ST_HOLD:   tmr_val = HOLD_LD;
      ST_POLL:   tmr_val = POLL_LD;
      ST_SETTLE: tmr_val = SETTLE_LD;
      default:   tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st_next = st_d;

  // R2: no progress while the supply is not good
  p_wait_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PWR && !start && !pwr_good) |=> st_q == ST_PWR);
  // R4: the hold interval is never cut short
  p_hold_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !start && !tmr_zero) |=> st_q == ST_HOLD);
  // R5: link-up inside the window always wins over expiry
  p_link_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POLL && !start && link_up) |=>
      (st_q == ST_READY || st_q == ST_SETTLE));
  // R7: the fault holds until a start request
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAULT && !start) |=> st_q == ST_FAULT);

endmodule

// File: rtl/sbs_drive.sv
module sbs_drive
  import sbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sbs_state_e st_next,
  output logic       pwr_en,
  output logic       refclk_en,
  output logic       perst_n,
  output logic       ready,
  output logic       timeout_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_en      <= 1'b0;
      refclk_en   <= 1'b0;
      perst_n     <= 1'b0;
      ready       <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      pwr_en      <= (st_next != ST_IDLE);
      refclk_en   <= (st_next != ST_IDLE) && (st_next != ST_PWR);
      perst_n     <= (st_next == ST_POLL) || (st_next == ST_SETTLE) ||
                     (st_next == ST_READY);
      ready       <= (st_next == ST_READY);
      timeout_err <= (st_next == ST_FAULT);
    end
  end

  // R4: reset is released only with the clock already running
  p_clk_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_n) |-> $past(refclk_en));
  // R7: a fault re-asserts reset on the slot
  p_fault_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !perst_n && !ready);

endmodule

// File: rtl/slot_bringup_seq.sv
module slot_bringup_seq
  import sbs_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned PERST_MS  = 100,
  parameter int unsigned LEAD_US   = 100,
  parameter int unsigned POLL_MS   = 100,
  parameter int unsigned SETTLE_MS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pwr_good,
  input  logic       link_up,
  input  logic [1:0] max_speed,
  output logic       pwr_en,
  output logic       refclk_en,
  output logic       perst_n,
  output logic       ready,
  output logic       timeout_err
);
  localparam int unsigned PERST_CYC  = cycles_for(CLK_HZ, PERST_MS, 1000);
  localparam int unsigned LEAD_CYC   = cycles_for(CLK_HZ, LEAD_US, 1_000_000);
  localparam int unsigned HOLD_CYC   = umax(PERST_CYC, LEAD_CYC);
  localparam int unsigned POLL_CYC   = cycles_for(CLK_HZ, POLL_MS, 1000);
  localparam int unsigned SETTLE_CYC = cycles_for(CLK_HZ, SETTLE_MS, 1000);
  localparam int unsigned CNT_MAX    = umax(HOLD_CYC, umax(POLL_CYC, SETTLE_CYC));
  localparam int          CW         = $clog2(CNT_MAX + 1);

  logic          fast, tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;
  sbs_state_e    st_next;

  sbs_speed u_speed (
    .max_speed (max_speed),
    .fast      (fast)
  );

  sbs_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sbs_fsm #(
    .CW(CW), .HOLD_CYC(HOLD_CYC), .POLL_CYC(POLL_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pwr_good (pwr_good),
    .link_up  (link_up),
    .fast     (fast),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .st_next  (st_next)
  );

  sbs_drive u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_next     (st_next),
    .pwr_en      (pwr_en),
    .refclk_en   (refclk_en),
    .perst_n     (perst_n),
    .ready       (ready),
    .timeout_err (timeout_err)
  );

  // R6: ready only with the slot fully up and no fault
  p_ready_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (perst_n && refclk_en && pwr_en && !timeout_err));
  // R8: start while active aborts to idle
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pwr_en) |=> (!pwr_en && !refclk_en && !perst_n && !ready));
  // R1: clock and reset release never run without power
  p_power_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (!refclk_en && !perst_n));

endmodule

// File: tb/sim_slot_bringup_seq.sv
module sim_slot_bringup_seq;
  localparam int unsigned HZ = 20_000;
  // expected cycle counts, computed from the requirement formulas
  localparam int HOLD_E   = ((HZ * 100 + 999) / 1000 > (HZ * 100 + 999_999) / 1_000_000)
                            ? (HZ * 100 + 999) / 1000 : (HZ * 100 + 999_999) / 1_000_000;
  localparam int POLL_E   = (HZ * 100 + 999) / 1000;
  localparam int SETTLE_E = (HZ * 100 + 999) / 1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pwr_good = 1'b0, link_up = 1'b0;
  logic [1:0] max_speed = 2'd0;
  logic pwr_en, refclk_en, perst_n, ready, timeout_err;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  slot_bringup_seq #(.CLK_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pwr_good(pwr_good),
    .link_up(link_up), .max_speed(max_speed), .pwr_en(pwr_en),
    .refclk_en(refclk_en), .perst_n(perst_n), .ready(ready),
    .timeout_err(timeout_err)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " pwr_en"}, pwr_en, 0);
    chk({req, " refclk_en"}, refclk_en, 0);
    chk({req, " perst_n"}, perst_n, 0);
    chk({req, " ready"}, ready, 0);
    chk({req, " timeout_err"}, timeout_err, 0);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // from idle: start, supply good at once; returns cycles seen in hold
  task automatic run_to_poll(output int hold_n);
    pulse_start();
    pwr_good = 1'b1;
    hold_n = 0;
    do begin
      @(negedge clk);
      if (refclk_en && !perst_n) hold_n++;
    end while (!perst_n && hold_n < 3 * HOLD_E);
  endtask

  // wait m cycles into the poll window, raise link_up, count to ready/err
  task automatic link_after(input int m, output int k);
    repeat (m) @(negedge clk);
    link_up = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!ready && !timeout_err && k < 3 * SETTLE_E);
  endtask

  task automatic back_to_idle();
    pulse_start();
    link_up = 1'b0;
    pwr_good = 1'b0;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int h, k;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1 after reset");

    // R2: power on, supply not yet good
    pulse_start();
    chk("R2 pwr_en next cycle", pwr_en, 1);
    repeat (100) @(negedge clk);
    chk("R2 refclk_en waits for pwr_good", refclk_en, 0);
    chk("R2 perst_n waits for pwr_good", perst_n, 0);
    chk("R2 pwr_en held", pwr_en, 1);
    // R3: supply good -> clock on one cycle later, reset still held
    pwr_good = 1'b1;
    @(negedge clk);
    chk("R3 refclk_en after pwr_good", refclk_en, 1);
    chk("R3 perst_n still low", perst_n, 0);
    back_to_idle();
    chk_idle("R8 abort during hold");

    // R4 R5 R6: sweep all speed codes and several link-up offsets
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 3; v++) begin
        int m;
        m = (v == 0) ? 0 : (v == 1) ? 37 : POLL_E - 1;
        max_speed = 2'(s);
        run_to_poll(h);
        chk($sformatf("R4 hold cycles spd%0d", s), h, HOLD_E);
        chk("R4 perst_n released", perst_n, 1);
        link_after(m, k);
        max_speed = 2'(3 - s);  // later changes must not matter
        chk($sformatf("R6 ready delay spd%0d m%0d", s, m), k, (s >= 2) ? SETTLE_E + 1 : 1);
        chk($sformatf("R5 no timeout m%0d", m), timeout_err, 0);
        link_up = 1'b0;
        repeat (20) @(negedge clk);
        chk("R6 ready held", ready, 1);
        chk("R6 perst_n high in ready", perst_n, 1);
        back_to_idle();
        chk_idle("R8 start in ready");
      end
    end

    // R7: link-up one cycle too late
    max_speed = 2'd0;
    run_to_poll(h);
    link_after(POLL_E, k);
    chk("R7 timeout_err", timeout_err, 1);
    chk("R7 ready low", ready, 0);
    chk("R7 perst_n reasserted", perst_n, 0);
    chk("R7 pwr_en kept", pwr_en, 1);
    chk("R7 refclk_en kept", refclk_en, 1);
    repeat (50) @(negedge clk);
    chk("R7 fault sticky with link_up", timeout_err, 1);
    chk("R7 ready stays low", ready, 0);
    back_to_idle();
    chk_idle("R8 start clears fault");
    // R8: fresh sequence after the fault
    run_to_poll(h);
    chk("R8 new hold cycles", h, HOLD_E);
    link_after(5, k);
    chk("R8 new sequence ready", ready, 1);
    back_to_idle();

    // R9: reset in the middle of the settle delay
    max_speed = 2'd2;
    run_to_poll(h);
    link_up = 1'b1;
    repeat (100) @(negedge clk);
    chk("R9 settling, not ready", ready, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R9 reset mid-sequence");
    link_up = 1'b0;
    pwr_good = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_idle("R9 idle after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule